// File: doc/BRIEF.md
# Receive Descriptor Ring Writeback Engine

This block moves incoming frames from a byte stream into memory buffers that software hands out through per-queue rings of 16-byte descriptors. Up to eight queues are supported. Each frame arrives tagged with a queue number. The engine reads the queue's current descriptor and checks that software still owns nothing in it, meaning the engine-owned bit is set. It then stores two zero pad bytes followed by the frame bytes into the buffer. Next it writes the byte count, and only after that the status word with ownership released. Finally it follows the next-descriptor link to the following slot of the ring.

Software starts a queue by setting its enable bit in a command register and asks it to halt through a second group of bits in the same register. A halt request is honoured at once when the queue is idle; if a frame for that queue is being written, the enable bit stays visible until that frame's writeback has finished. When a fetched descriptor is not owned by the engine, the queue is switched off and the frame is discarded and counted. A descriptor may ask for an interrupt; completion then raises a per-queue cause bit that software clears by writing ones.

Descriptor layout, word by word from the descriptor address: word 0 is status/command, word 1 carries the buffer size in bits 15:0 and the reported byte count in bits 31:16, word 2 is the buffer address (word aligned), word 3 is the link to the next descriptor.

Top module: `rxd_ring_wb`

## Requirements
- R1: After reset the command register (address 0x280) reads 0, rx_ready and rx_irq are 0, the discard counter (address 0x28C) reads 0 and every current-descriptor pointer reads 0.
- R2: A register write to 0x280 with bit q (q in 0..7) set enables queue q; reading 0x280 returns the enable state of queue q in bit q.
- R3: A write to 0x280 with bit q+8 set asks queue q to halt; when no frame of queue q is in progress its enable bit reads 0 on the next read, otherwise it keeps reading 1 until that frame's status has been written and then reads 0.
- R4: For a frame on an enabled queue the engine reads the four descriptor words at the queue's current pointer and uses word 0 bit 31 as ownership, word 0 bit 29 as interrupt request, word 1 bits 15:0 as buffer size, word 2 as buffer address and word 3 as next link.
- R5: The buffer receives two zero bytes followed by the frame bytes in order, byte i of the buffer at address buffer+i, and word 1 bits 31:16 are written with the frame length plus two.
- R6: The status word written back has bit 31 clear, bits 27 and 26 set, bit 29 copied from the fetched word, bit 0 set when the stream flagged an error and all other bits clear; the count word is written in the cycle before the status word.
- R7: When frame length plus two exceeds the buffer size, only the first buffer-size bytes are stored, the count reports the buffer size, status bit 0 is set and no byte past the buffer is touched.
- R8: When the fetched word 0 has bit 31 clear, the frame is consumed and dropped, the queue's enable bit is cleared, the discard counter increments, and neither the descriptor, the buffer nor the current pointer changes.
- R9: A frame tagged with a disabled queue is consumed and dropped without any memory access, and the discard counter increments.
- R10: After writeback the queue's current pointer equals the fetched next link, so consecutive frames walk the ring.
- R11: Completion of a descriptor with bit 29 set sets rx_irq bit q; with bit 29 clear it does not; writing a one to bit q at 0x288 clears it.
- R12: The current pointer of queue q is read and written at 0x20C + 16*q.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| rx_valid | input | 1 | Frame byte valid |
| rx_ready | output | 1 | Engine accepts a byte this cycle |
| rx_data | input | 8 | Frame byte |
| rx_last | input | 1 | Byte is the final byte of the frame |
| rx_err | input | 1 | Frame error flag, sampled with every byte |
| rx_queue | input | 3 | Queue number of the frame, held for the whole frame |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Write when 1, read when 0 |
| mem_addr | output | 32 | Byte address, word aligned |
| mem_be | output | 4 | Byte lane strobes for writes |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, one cycle after the read request |
| rx_irq | output | 8 | Per-queue receive interrupt cause |

## Verification
The two functions that can collide are a software halt request for a queue and the engine's writeback of a frame on that same queue. The bench starts a long frame on queue 0 and, while bytes are still streaming, writes the halt bit from a parallel thread. It then reads the command register mid-frame, expecting the enable bit still set, and reads it again after writeback, expecting it cleared. It also confirms that the interrupted frame's data, count and status were written intact, and a bound property states that an enabled busy queue never loses its enable bit except through an ownership miss.

// File: rtl/rxw_pkg.sv
package rxw_pkg;
   localparam int WORD_W   = 32;
   localparam int CNT_W    = 16;
   localparam int OWN_BIT  = 31;
   localparam int IRQ_BIT  = 29;
   localparam int HEAD_BIT = 27;
   localparam int TAIL_BIT = 26;
   localparam int PAD_BYTES = 2;

   typedef enum logic [2:0] {
      S_IDLE, S_FETCH, S_FLAST, S_DATA, S_DROP, S_WBCNT, S_WBSTS
   } rxw_state_e;
endpackage

// File: rtl/rxw_regs.sv
module rxw_regs
   import rxw_pkg::*;
#(
   parameter int NQ       = 8,
   parameter int QW       = 3,
   parameter int RAW      = 12,
   parameter int CMD_A    = 'h280,
   parameter int CAUSE_A  = 'h288,
   parameter int DROP_A   = 'h28C,
   parameter int PTR_A    = 'h20C,
   parameter int PTR_S    = 16,
   parameter int DCW      = 16,
   parameter bit DISC_SAT = 1'b1
)(
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       reg_wr,
   input  logic [RAW-1:0]             reg_addr,
   input  logic [WORD_W-1:0]          reg_wdata,
   output logic [WORD_W-1:0]          reg_rdata,
   input  logic [NQ-1:0]              busy_vec,
   input  logic                       own_fail_p,
   input  logic                       drop_p,
   input  logic                       done_p,
   input  logic                       irq_req,
   input  logic [QW-1:0]              cur_q,
   input  logic [WORD_W-1:0]          next_ptr,
   output logic [NQ-1:0]              en_vec,
   output logic [NQ-1:0][WORD_W-1:0]  ptr_arr,
   output logic [NQ-1:0]              cause
);
   if (DCW < 1 || DCW > WORD_W) begin : g_bad_dcw
      $error("rxw_regs: DCW out of range");
   end

   logic [NQ-1:0] en_q, st_q, en_nx, st_nx, cause_nx;
   logic [DCW-1:0] disc_q;
   logic cmd_wr, cause_wr;

   assign cmd_wr   = reg_wr && (reg_addr == RAW'(CMD_A));
   assign cause_wr = reg_wr && (reg_addr == RAW'(CAUSE_A));

   always_comb begin
      en_nx    = en_q;
      st_nx    = st_q;
      cause_nx = cause;
      for (int q = 0; q < NQ; q++) begin
         if (cmd_wr && reg_wdata[q])     en_nx[q] = 1'b1;
         if (cmd_wr && reg_wdata[8 + q]) st_nx[q] = 1'b1;
         if (st_nx[q] && !busy_vec[q]) begin
            en_nx[q] = 1'b0;
            st_nx[q] = 1'b0;
         end
         if (own_fail_p && cur_q == QW'(q)) begin
            en_nx[q] = 1'b0;
            st_nx[q] = 1'b0;
         end
         if (cause_wr && reg_wdata[q]) cause_nx[q] = 1'b0;
         if (done_p && irq_req && cur_q == QW'(q)) cause_nx[q] = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= '0;
         st_q  <= '0;
         cause <= '0;
      end else begin
         en_q  <= en_nx;
         st_q  <= st_nx;
         cause <= cause_nx;
      end
   end

   for (genvar g = 0; g < NQ; g++) begin : g_ptr
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            ptr_arr[g] <= '0;
         else if (done_p && cur_q == QW'(g))
            ptr_arr[g] <= next_ptr;
         else if (reg_wr && reg_addr == RAW'(PTR_A + g * PTR_S))
            ptr_arr[g] <= reg_wdata;
      end
   end

   if (DISC_SAT) begin : g_disc_sat
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                         disc_q <= '0;
         else if (drop_p && disc_q != '1)    disc_q <= disc_q + 1'b1;
      end
   end else begin : g_disc_wrap
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       disc_q <= '0;
         else if (drop_p)  disc_q <= disc_q + 1'b1;
      end
   end

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == RAW'(CMD_A))  reg_rdata = WORD_W'(en_q);
      if (reg_addr == RAW'(DROP_A)) reg_rdata = WORD_W'(disc_q);
      for (int q = 0; q < NQ; q++)
         if (reg_addr == RAW'(PTR_A + q * PTR_S)) reg_rdata = ptr_arr[q];
   end

   assign en_vec = en_q;
endmodule

// File: rtl/rxw_engine.sv
module rxw_engine
   import rxw_pkg::*;
#(
   parameter int NQ = 8,
   parameter int QW = 3
)(
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NQ-1:0]              en_vec,
   input  logic [NQ-1:0][WORD_W-1:0]  ptr_arr,
   input  logic                       rx_valid,
   input  logic [7:0]                 rx_data,
   input  logic                       rx_last,
   input  logic                       rx_err,
   input  logic [QW-1:0]              rx_queue,
   output logic                       rx_ready,
   output logic                       mem_req,
   output logic                       mem_we,
   output logic [WORD_W-1:0]          mem_addr,
   output logic [3:0]                 mem_be,
   output logic [WORD_W-1:0]          mem_wdata,
   input  logic [WORD_W-1:0]          mem_rdata,
   output logic [NQ-1:0]              busy_vec,
   output logic                       own_fail_p,
   output logic                       drop_p,
   output logic                       done_p,
   output logic [QW-1:0]              cur_q,
   output logic [WORD_W-1:0]          next_ptr,
   output logic                       irq_req
);
   rxw_state_e          state;
   logic [1:0]          k;
   logic                own_q, ie_q, err_q;
   logic [CNT_W-1:0]    bufsz, cnt;
   logic [WORD_W-1:0]   bptr, nxt, wbuf, merged, base;
   logic [3:0]          wbe, mbe;
   logic [1:0]          lane;
   logic                inb, take, flush;

   assign base  = ptr_arr[cur_q];
   assign inb   = (cnt < bufsz);
   assign lane  = cnt[1:0];
   assign take  = (state == S_DATA) && rx_valid;
   assign mbe   = wbe | (4'b0001 << lane);
   assign flush = take && ((inb && (lane == 2'd3 || rx_last)) ||
                           (!inb && rx_last && wbe != 4'b0000));

   always_comb begin
      merged = wbuf;
      merged[8*lane +: 8] = rx_data;
   end

   always_comb begin
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = '0;
      mem_be    = 4'b0000;
      mem_wdata = '0;
      case (state)
         S_FETCH: begin
            mem_req  = 1'b1;
            mem_addr = base + {28'd0, k, 2'b00};
         end
         S_DATA: if (flush) begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = bptr + {16'd0, cnt[CNT_W-1:2], 2'b00};
            mem_be    = inb ? mbe : wbe;
            mem_wdata = inb ? merged : wbuf;
         end
         S_WBCNT: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = base + 32'd4;
            mem_be    = 4'b1111;
            mem_wdata = {cnt, bufsz};
         end
         S_WBSTS: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = base;
            mem_be    = 4'b1111;
            mem_wdata = '0;
            mem_wdata[IRQ_BIT]  = ie_q;
            mem_wdata[HEAD_BIT] = 1'b1;
            mem_wdata[TAIL_BIT] = 1'b1;
            mem_wdata[0]        = err_q;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= S_IDLE;
         k     <= '0;
         own_q <= 1'b0;
         ie_q  <= 1'b0;
         err_q <= 1'b0;
         bufsz <= '0;
         cnt   <= '0;
         bptr  <= '0;
         nxt   <= '0;
         wbuf  <= '0;
         wbe   <= '0;
         cur_q <= '0;
      end else begin
         case (state)
            S_IDLE: if (rx_valid) begin
               cur_q <= rx_queue;
               cnt   <= CNT_W'(PAD_BYTES);
               wbuf  <= '0;
               wbe   <= 4'b0011;
               err_q <= 1'b0;
               k     <= '0;
               state <= en_vec[rx_queue] ? S_FETCH : S_DROP;
            end
            S_FETCH: begin
               k <= k + 2'd1;
               if (k == 2'd1) begin
                  own_q <= mem_rdata[OWN_BIT];
                  ie_q  <= mem_rdata[IRQ_BIT];
               end
               if (k == 2'd2) bufsz <= mem_rdata[CNT_W-1:0];
               if (k == 2'd3) begin
                  bptr  <= mem_rdata;
                  state <= S_FLAST;
               end
            end
            S_FLAST: begin
               nxt   <= mem_rdata;
               state <= own_q ? S_DATA : S_DROP;
            end
            S_DATA: if (rx_valid) begin
               err_q <= err_q | rx_err | ~inb;
               if (inb) cnt <= cnt + 1'b1;
               if (flush) begin
                  wbuf <= '0;
                  wbe  <= 4'b0000;
               end else if (inb) begin
                  wbuf <= merged;
                  wbe  <= mbe;
               end
               if (rx_last) state <= S_WBCNT;
            end
            S_DROP:  if (rx_valid && rx_last) state <= S_IDLE;
            S_WBCNT: state <= S_WBSTS;
            S_WBSTS: state <= S_IDLE;
            default: state <= S_IDLE;
         endcase
      end
   end

   for (genvar g = 0; g < NQ; g++) begin : g_busy
      assign busy_vec[g] = (state != S_IDLE && cur_q == QW'(g)) ||
                           (state == S_IDLE && rx_valid && rx_queue == QW'(g));
   end

   assign rx_ready   = (state == S_DATA) || (state == S_DROP);
   assign own_fail_p = (state == S_FLAST) && !own_q;
   assign drop_p     = (state == S_IDLE && rx_valid && !en_vec[rx_queue]) || own_fail_p;
   assign done_p     = (state == S_WBSTS);
   assign next_ptr   = nxt;
   assign irq_req    = ie_q;
endmodule

// File: rtl/rxd_ring_wb.sv
module rxd_ring_wb
   import rxw_pkg::*;
#(
   parameter  int NQ       = 8,
   parameter  int RAW      = 12,
   parameter  int DCW      = 16,
   parameter  bit DISC_SAT = 1'b1,
   localparam int QW       = (NQ > 1) ? $clog2(NQ) : 1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [RAW-1:0]    reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic              rx_valid,
   output logic              rx_ready,
   input  logic [7:0]        rx_data,
   input  logic              rx_last,
   input  logic              rx_err,
   input  logic [QW-1:0]     rx_queue,
   output logic              mem_req,
   output logic              mem_we,
   output logic [31:0]       mem_addr,
   output logic [3:0]        mem_be,
   output logic [31:0]       mem_wdata,
   input  logic [31:0]       mem_rdata,
   output logic [NQ-1:0]     rx_irq
);
   if (NQ < 2 || NQ > 8) begin : g_bad_nq
      $error("rxd_ring_wb: NQ must lie in 2..8");
   end
   if (RAW < 10) begin : g_bad_raw
      $error("rxd_ring_wb: RAW too narrow for the register map");
   end

   logic [NQ-1:0]             en_vec, busy_vec;
   logic [NQ-1:0][WORD_W-1:0] ptr_arr;
   logic                      own_fail_p, drop_p, done_p, irq_req;
   logic [QW-1:0]             cur_q;
   logic [WORD_W-1:0]         next_ptr;

   rxw_engine #(.NQ(NQ), .QW(QW)) u_engine (
      .clk(clk), .rst_n(rst_n), .en_vec(en_vec), .ptr_arr(ptr_arr),
      .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last),
      .rx_err(rx_err), .rx_queue(rx_queue), .rx_ready(rx_ready),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .busy_vec(busy_vec), .own_fail_p(own_fail_p), .drop_p(drop_p),
      .done_p(done_p), .cur_q(cur_q), .next_ptr(next_ptr), .irq_req(irq_req)
   );

   rxw_regs #(.NQ(NQ), .QW(QW), .RAW(RAW), .DCW(DCW), .DISC_SAT(DISC_SAT)) u_regs (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy_vec(busy_vec),
      .own_fail_p(own_fail_p), .drop_p(drop_p), .done_p(done_p),
      .irq_req(irq_req), .cur_q(cur_q), .next_ptr(next_ptr),
      .en_vec(en_vec), .ptr_arr(ptr_arr), .cause(rx_irq)
   );
endmodule

// File: rtl/rxd_ring_wb_chk.sv
module rxd_ring_wb_chk #(
   parameter int NQ = 8,
   parameter int QW = 3
)(
   input logic          clk,
   input logic          rst_n,
   input logic          mem_req,
   input logic          mem_we,
   input logic [31:0]   mem_addr,
   input logic [3:0]    mem_be,
   input logic [31:0]   mem_wdata,
   input logic          done_p,
   input logic          own_fail_p,
   input logic [QW-1:0] cur_q,
   input logic [NQ-1:0] en_vec,
   input logic [NQ-1:0] busy_vec
);
   assert_sts_owner_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done_p |-> (mem_req && mem_we && !mem_wdata[31]));

   assert_cnt_before_sts_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done_p |-> ($past(mem_req && mem_we) && $past(mem_addr) == mem_addr + 32'd4));

   assert_missown_disable_R8: assert property (@(posedge clk) disable iff (!rst_n)
      own_fail_p |=> !en_vec[$past(cur_q)]);

   assert_no_midframe_stop_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(own_fail_p) |-> (($past(busy_vec & en_vec) & busy_vec & ~en_vec) == '0));

   assert_write_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> (mem_be != 4'b0000));

   assert_single_event_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({done_p, own_fail_p}));
endmodule

bind rxd_ring_wb rxd_ring_wb_chk #(.NQ(NQ), .QW(QW)) u_chk (
   .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we),
   .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
   .done_p(done_p), .own_fail_p(own_fail_p), .cur_q(cur_q),
   .en_vec(en_vec), .busy_vec(busy_vec)
);

// File: tb/rxd_ring_wb_bench.sv
`timescale 1ns/1ps
module rxd_ring_wb_bench;
   localparam int CMD = 'h280, CAUSE = 'h288, DROPC = 'h28C, PTR0 = 'h20C;

   logic clk = 1'b0, rst_n = 1'b0;
   logic reg_wr = 1'b0;
   logic [11:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0, reg_rdata;
   logic rx_valid = 1'b0, rx_ready, rx_last = 1'b0, rx_err = 1'b0;
   logic [7:0] rx_data = '0;
   logic [2:0] rx_queue = '0;
   logic mem_req, mem_we;
   logic [31:0] mem_addr, mem_wdata, mem_rdata;
   logic [3:0] mem_be;
   logic [7:0] rx_irq;

   logic [31:0] mem [0:1023];
   logic tb_we = 1'b0;
   logic [9:0] tb_idx = '0;
   logic [31:0] tb_d = '0;
   logic [7:0] fb [0:63];
   int checks = 0, errors = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   rxd_ring_wb u_rxd_ring_wb (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_valid(rx_valid),
      .rx_ready(rx_ready), .rx_data(rx_data), .rx_last(rx_last),
      .rx_err(rx_err), .rx_queue(rx_queue), .mem_req(mem_req),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .rx_irq(rx_irq)
   );

   always @(posedge clk) begin
      if (tb_we) mem[tb_idx] <= tb_d;
      else if (mem_req) begin
         if (mem_we) begin
            for (int b = 0; b < 4; b++)
               if (mem_be[b]) mem[mem_addr[11:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
         end else mem_rdata <= mem[mem_addr[11:2]];
      end
   end

   task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s act=%h exp=%h", rq, act, exp);
      end
   endtask

   task automatic reg_write(input int a, input logic [31:0] d);
      @(negedge clk); reg_wr = 1'b1; reg_addr = a[11:0]; reg_wdata = d;
      @(negedge clk); reg_wr = 1'b0;
   endtask

   task automatic reg_rd(input int a, output logic [31:0] d);
      @(negedge clk); reg_addr = a[11:0]; #1; d = reg_rdata;
   endtask

   task automatic poke(input int a, input logic [31:0] d);
      @(negedge clk); tb_we = 1'b1; tb_idx = a[11:2]; tb_d = d;
      @(negedge clk); tb_we = 1'b0;
   endtask

   function automatic logic [7:0] mbyte(input int a);
      return mem[a >> 2][8*(a & 3) +: 8];
   endfunction

   task automatic set_desc(input int d, input bit own, input bit ie, input int bsz,
                           input int b, input int nx);
      poke(d, {own, 1'b0, ie, 29'd0});
      poke(d + 4, {16'd0, bsz[15:0]});
      poke(d + 8, b);
      poke(d + 12, nx);
      for (int i = 0; i < (bsz + 8) / 4 + 1; i++) poke(b + 4 * i, 32'hA5A5A5A5);
   endtask

   task automatic send(input int q, input int n, input bit e);
      for (int i = 0; i < n; i++) fb[i] = 8'($urandom);
      @(negedge clk);
      for (int i = 0; i < n; i++) begin
         rx_valid = 1'b1; rx_queue = q[2:0]; rx_data = fb[i];
         rx_last = (i == n - 1); rx_err = e && (i == n / 2);
         #1;
         while (!rx_ready) begin @(negedge clk); #1; end
         @(negedge clk);
      end
      rx_valid = 1'b0; rx_last = 1'b0; rx_err = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic verify(input string rq, input int q, input int d, input int b,
                         input int n, input int bsz, input bit e, input bit ie, input int nx);
      int ecnt, bad;
      logic [31:0] r;
      ecnt = (n + 2 > bsz) ? bsz : n + 2;
      chk({rq, " R6 status"}, mem[d >> 2],
          32'h0C00_0000 | (32'(ie) << 29) | 32'((e || (n + 2 > bsz)) ? 1 : 0));
      chk({rq, " R5 count"}, {16'd0, mem[(d + 4) >> 2][31:16]}, 32'(ecnt));
      bad = 0;
      for (int i = 0; i < ecnt; i++)
         if (mbyte(b + i) !== ((i < 2) ? 8'h00 : fb[i - 2])) bad++;
      chk({rq, " R5 data"}, 32'(bad), 32'd0);
      chk({rq, " R7 past buffer"}, {24'd0, mbyte(b + ecnt)}, 32'h0000_00A5);
      reg_rd(PTR0 + 16 * q, r);
      chk({rq, " R10 pointer"}, r, 32'(nx));
      chk({rq, " R11 cause"}, {31'd0, rx_irq[q]}, {31'd0, ie});
   endtask

   initial begin
      int seed;
      seed = $urandom(32'd2024);
      repeat (100000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] r;
      for (int i = 0; i < 1024; i++) mem[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      reg_rd(CMD, r);   chk("R1 cmd", r, 32'd0);
      reg_rd(DROPC, r); chk("R1 discard", r, 32'd0);
      reg_rd(PTR0, r);  chk("R1 pointer", r, 32'd0);
      chk("R1 ready", {31'd0, rx_ready}, 32'd0);
      chk("R1 irq", {24'd0, rx_irq}, 32'd0);

      // R12 pointer registers
      reg_write(PTR0 + 16 * 3, 32'h1234);
      reg_rd(PTR0 + 48, r); chk("R12 ptr3", r, 32'h1234);
      reg_rd(PTR0, r);      chk("R12 ptr0", r, 32'd0);

      // R2 enable
      reg_write(CMD, 32'h0F);
      reg_rd(CMD, r); chk("R2 enable", r, 32'h0F);

      // R9 disabled queue
      send(5, 12, 1'b0);
      reg_rd(DROPC, r); chk("R9 discard", r, 32'd1);
      reg_rd(CMD, r);   chk("R9 cmd", r, 32'h0F);

      // R4 R5 R6 R10 R11 normal frame, queue 0
      set_desc('h000, 1'b1, 1'b1, 64, 'h800, 'h020);
      set_desc('h020, 1'b1, 1'b0, 64, 'h880, 'h000);
      reg_write(PTR0, 32'h000);
      send(0, 16, 1'b0);
      verify("R4 q0", 0, 'h000, 'h800, 16, 64, 1'b0, 1'b1, 'h020);
      reg_write(CAUSE, 32'h1);
      chk("R11 clear", {24'd0, rx_irq}, 32'd0);

      // R6 error flag, queue 1
      set_desc('h040, 1'b1, 1'b0, 64, 'h900, 'h060);
      reg_write(PTR0 + 16, 32'h040);
      send(1, 21, 1'b1);
      verify("R6 err", 1, 'h040, 'h900, 21, 64, 1'b1, 1'b0, 'h060);

      // R7 truncation, queue 2
      set_desc('h080, 1'b1, 1'b0, 12, 'hA00, 'h0A0);
      reg_write(PTR0 + 32, 32'h080);
      send(2, 20, 1'b0);
      verify("R7 trunc", 2, 'h080, 'hA00, 20, 12, 1'b0, 1'b0, 'h0A0);

      // R8 ownership miss, queue 3
      set_desc('h0C0, 1'b0, 1'b1, 32, 'hB00, 'h0E0);
      reg_write(PTR0 + 48, 32'h0C0);
      send(3, 10, 1'b0);
      reg_rd(CMD, r);   chk("R8 enable cleared", r, 32'h07);
      reg_rd(DROPC, r); chk("R8 discard", r, 32'd2);
      reg_rd(PTR0 + 48, r); chk("R8 pointer kept", r, 32'h0C0);
      chk("R8 descriptor kept", mem['h0C0 >> 2], 32'h2000_0000);
      chk("R8 buffer kept", {24'd0, mbyte('hB02)}, 32'h0000_00A5);

      // R10 ring walk, queue 0 second slot
      send(0, 33, 1'b0);
      verify("R10 ring", 0, 'h020, 'h880, 33, 64, 1'b0, 1'b0, 'h000);

      // R3 halt while idle
      reg_write(CMD, 32'h0200);
      reg_rd(CMD, r); chk("R3 idle halt", r, 32'h05);

      // R3 halt request during a frame of the same queue
      set_desc('h000, 1'b1, 1'b0, 64, 'h800, 'h020);
      fork
         send(0, 30, 1'b0);
         begin
            repeat (14) @(negedge clk);
            reg_write(CMD, 32'h0100);
            reg_rd(CMD, r); chk("R3 held mid-frame", r & 32'h1, 32'h1);
         end
      join
      verify("R3 frame", 0, 'h000, 'h800, 30, 64, 1'b0, 1'b0, 'h020);
      reg_rd(CMD, r); chk("R3 halted after", r, 32'h04);

      // random frames over all queues
      reg_write(CMD, 32'hFF);
      for (int it = 0; it < 24; it++) begin
         int q, n, bsz, d, b;
         bit e, ie;
         q = $urandom % 8; n = 1 + $urandom % 60; bsz = 8 + $urandom % 57;
         e = ($urandom % 4) == 0; ie = $urandom % 2;
         d = 'h200 + q * 'h20; b = 'h800 + q * 'h100;
         set_desc(d, 1'b1, ie, bsz, b, d + 'h10);
         reg_write(PTR0 + 16 * q, d);
         send(q, n, e);
         verify("R5 random", q, d, b, n, bsz, e, ie, d + 'h10);
         reg_write(CAUSE, 32'hFF);
      end

      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule